// File: doc/BRIEF.md
# Machine-Cycle Timer/Event Counter

A 16-bit up-counter for a small microcontroller peripheral set. The oscillator clock is divided into machine cycles of 12 oscillator periods, shown as 6 states of 2 phases each. In timer mode the count advances by one in every machine cycle. In event mode it advances once for each falling edge on an external pin. The edge is found by sampling the pin once per machine cycle.

Software sees the count as two 8-bit bytes that it can read and load. It starts and stops counting with a run enable and selects the source with one select bit. A sticky overflow flag records every wrap of the count. Internally, one strobe picks the pin-sampling phase and a second strobe picks the phase at which a new count value is committed. The pin samples form a two-sample history.

Top module: `mct_timer`

## Requirements
- R1: While `rst_n` is low, `cnt_hi`, `cnt_lo` and `ovf_flag` are all 0.
- R2: With `run_en`=1 and `sel_count`=0 (timer), the 16-bit count {`cnt_hi`,`cnt_lo`} increases by exactly one every 12 oscillator clocks, never by more than one.
- R3: With `sel_count`=1 (event), `ev_pin` is sampled once per machine cycle, at state 5 phase 2 (oscillator tick 9 of ticks 0..11). The count advances by one exactly when the sample of one machine cycle is 1 and the sample of the next machine cycle is 0. Rising edges and a steady level add nothing.
- R4: A count change that is not caused by a write happens only at state 3 phase 1 (tick 4). This is 7 clocks after the sample that recognised the edge, in the following machine cycle.
- R5: A low pulse on `ev_pin` that starts and ends between two sampling points is not counted. Because of this, at most one event is counted per two machine cycles (oscillator frequency / 24).
- R6: With `run_en`=0 the count holds its value. An edge recognised while stopped is discarded at its commit point.
- R7: A change of the count from 0xFFFF to 0x0000 by increment sets `ovf_flag`. The flag stays 1 until a `clr_ovf` pulse clears it. If a wrap and `clr_ovf` happen in the same clock, the flag is left set.
- R8: `wr_hi`/`wr_lo` load `wr_data` into the high or low byte on the next clock. A write suppresses any increment due in that same clock, so the written value appears unchanged.
- R9: The sampling strobe and the commit strobe are each one clock wide. They are never active together, and each fires once in every 12 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | 1 lets the count advance |
| sel_count | input | 1 | 0 = timer (machine cycles), 1 = event (pin falling edges) |
| ev_pin | input | 1 | External event input |
| wr_lo | input | 1 | Load `wr_data` into the low byte |
| wr_hi | input | 1 | Load `wr_data` into the high byte |
| wr_data | input | 8 | Byte to load |
| clr_ovf | input | 1 | Clear the overflow flag |
| cnt_lo | output | 8 | Low byte of the count |
| cnt_hi | output | 8 | High byte of the count |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that `ev_pin`, `run_en`, `sel_count` and the write strobes are synchronous to `clk_osc`, so a sample never sees a changing level. They also assume that a write and a commit strobe meet only in the way R8 defines. The stimulus changes every input on the falling clock edge. Each stimulus step is aligned to whole machine cycles, found from the first timer increment after reset. Single-clock writes, clears and glitches are placed at chosen offsets inside a machine cycle so that they hit or miss the sampling and commit points on purpose.

// File: rtl/mct_pkg.sv
package mct_pkg;
  // Machine-cycle geometry
  localparam int MC_STATES = 6;
  localparam int MC_PHASES = 2;
  // Pin sampling point: state 5, phase 2
  localparam int SMP_STATE = 5;
  localparam int SMP_PHASE = 2;
  // Commit point: state 3, phase 1
  localparam int LD_STATE  = 3;
  localparam int LD_PHASE  = 1;
  // Count register geometry
  localparam int BYTE_BITS = 8;
  localparam int CNT_BYTES = 2;

  typedef enum logic {
    SRC_TIMER = 1'b0,
    SRC_EVENT = 1'b1
  } mct_src_e;
endpackage

// File: rtl/mct_rst_sync.sv
module mct_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/mct_phase_gen.sv
module mct_phase_gen
  import mct_pkg::*;
#(
  parameter int STATES    = MC_STATES,
  parameter int PHASES    = MC_PHASES,
  parameter int S_STATE   = SMP_STATE,
  parameter int S_PHASE   = SMP_PHASE,
  parameter int L_STATE   = LD_STATE,
  parameter int L_PHASE   = LD_PHASE
) (
  input  logic clk,
  input  logic rst_n,
  output logic smp_stb,
  output logic ld_stb
);
  localparam int TICKS   = STATES * PHASES;
  localparam int IDX_W   = $clog2(TICKS);
  localparam int SMP_IDX = (S_STATE - 1) * PHASES + (S_PHASE - 1);
  localparam int LD_IDX  = (L_STATE - 1) * PHASES + (L_PHASE - 1);

  logic [IDX_W-1:0] tick_q, tick_d;

  always_comb begin
    if (tick_q == IDX_W'(TICKS - 1)) tick_d = '0;
    else                             tick_d = tick_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end

  assign smp_stb = (tick_q == IDX_W'(SMP_IDX));
  assign ld_stb  = (tick_q == IDX_W'(LD_IDX));

  // R9: strobes never coincide and are each one clock wide
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({smp_stb, ld_stb}));
  assert_ld_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> !ld_stb);
  assert_smp_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !smp_stb);
  assert_tick_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q < IDX_W'(TICKS));
endmodule

// File: rtl/mct_edge_sampler.sv
module mct_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_stb,
  input  logic ld_stb,
  input  logic pin,
  output logic evt_pend
);
  logic last_smp_q, last_smp_d;
  logic pend_q, pend_d;
  logic upd_en;

  // The history resets to 0 so that a low pin right after reset is not taken as an edge
  always_comb begin
    last_smp_d = last_smp_q;
    pend_d     = pend_q;
    if (smp_stb) begin
      last_smp_d = pin;
      pend_d     = last_smp_q & ~pin;
    end else if (ld_stb) begin
      pend_d     = 1'b0;
    end
  end

  assign upd_en = smp_stb | ld_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_smp_q <= 1'b0;
      pend_q     <= 1'b0;
    end else if (upd_en) begin
      last_smp_q <= last_smp_d;
      pend_q     <= pend_d;
    end
  end

  assign evt_pend = pend_q;

  // R3: a pending event only appears right after a sampling strobe
  assert_pend_from_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_pend) |-> $past(smp_stb));
  // R4: a pending event is consumed by the next commit strobe
  assert_pend_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pend && ld_stb) |=> !evt_pend);
endmodule

// File: rtl/mct_count_core.sv
module mct_count_core #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inc_req,
  input  logic [NBYTES-1:0]        wr_en,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic                     clr_ovf,
  output logic [BYTE_W*NBYTES-1:0] count,
  output logic                     ovf
);
  localparam int CNT_W = BYTE_W * NBYTES;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             ovf_q, ovf_d;
  logic             any_wr, bump, wrap, cnt_en;

  assign any_wr  = |wr_en;
  assign bump    = inc_req & ~any_wr;
  assign wrap    = bump & (&cnt_q);
  assign cnt_inc = cnt_q + 1'b1;
  assign cnt_en  = any_wr | bump;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign cnt_d[b*BYTE_W +: BYTE_W] =
      wr_en[b] ? wr_data :
      bump     ? cnt_inc[b*BYTE_W +: BYTE_W] :
                 cnt_q[b*BYTE_W +: BYTE_W];
  end

  always_comb begin
    ovf_d = ovf_q;
    if (wrap)         ovf_d = 1'b1;
    else if (clr_ovf) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign count = cnt_q;
  assign ovf   = ovf_q;

  // R2: an increment without a write advances by exactly one
  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && !any_wr) |=> (count == $past(count) + 1'b1));
  // R8: a write wins over an increment in the same clock
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[0] && inc_req) |=> (count[BYTE_W-1:0] == $past(wr_data)));
  // R7: a wrap always leaves the flag set, even against a clear
  assert_ovf_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && !any_wr && (&count)) |=> (ovf && count == '0));
  // R7: the flag only rises on a wrap
  assert_ovf_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> ($past(inc_req) && $past(&count)));
endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter int BYTE_W = BYTE_BITS
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              sel_count,
  input  logic              ev_pin,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              clr_ovf,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              ovf_flag
);
  localparam int NB    = CNT_BYTES;
  localparam int CNT_W = BYTE_W * NB;

  logic             rst_i_n;
  logic             smp_stb, ld_stb, evt_pend;
  logic             src_hit, inc_req;
  logic [NB-1:0]    wr_en;
  logic [CNT_W-1:0] count;
  mct_src_e         src;

  mct_rst_sync u_rst_sync (
    .clk        (clk_osc),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  mct_phase_gen u_phase (
    .clk     (clk_osc),
    .rst_n   (rst_i_n),
    .smp_stb (smp_stb),
    .ld_stb  (ld_stb)
  );

  mct_edge_sampler u_edge (
    .clk      (clk_osc),
    .rst_n    (rst_i_n),
    .smp_stb  (smp_stb),
    .ld_stb   (ld_stb),
    .pin      (ev_pin),
    .evt_pend (evt_pend)
  );

  assign src     = mct_src_e'(sel_count);
  assign src_hit = (src == SRC_EVENT) ? evt_pend : 1'b1;
  assign inc_req = ld_stb & run_en & src_hit;
  assign wr_en   = {wr_hi, wr_lo};

  mct_count_core #(.BYTE_W(BYTE_W), .NBYTES(NB)) u_core (
    .clk     (clk_osc),
    .rst_n   (rst_i_n),
    .inc_req (inc_req),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .clr_ovf (clr_ovf),
    .count   (count),
    .ovf     (ovf_flag)
  );

  assign cnt_lo = count[BYTE_W-1:0];
  assign cnt_hi = count[CNT_W-1:BYTE_W];

  // R6: stopped and not written, the count is held
  assert_hold_stopped_R6: assert property (@(posedge clk_osc) disable iff (!rst_i_n)
    (!run_en && !wr_lo && !wr_hi) |=> $stable(count));
  // R4: any change not caused by a write follows a commit strobe
  assert_commit_phase_R4: assert property (@(posedge clk_osc) disable iff (!rst_i_n)
    (!$stable(count) && !$past(wr_lo) && !$past(wr_hi)) |-> $past(ld_stb));
  // R3: in event mode there is no count change without a recognised edge
  assert_event_only_R3: assert property (@(posedge clk_osc) disable iff (!rst_i_n)
    (sel_count && !evt_pend && !wr_lo && !wr_hi) |=> $stable(count));
endmodule

// File: tb/mct_timer_bench.sv
module mct_timer_bench;
  logic       clk_osc = 1'b0;
  logic       rst_n;
  logic       run_en, sel_count, ev_pin, wr_lo, wr_hi, clr_ovf;
  logic [7:0] wr_data;
  logic [7:0] cnt_lo, cnt_hi;
  logic       ovf_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_osc = ~clk_osc;

  mct_timer u_mct_timer (
    .clk_osc   (clk_osc),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .sel_count (sel_count),
    .ev_pin    (ev_pin),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wr_data   (wr_data),
    .clr_ovf   (clr_ovf),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .ovf_flag  (ovf_flag)
  );

  // Each row covers one machine cycle: {pin, run, sel, expected ovf, expected count at its end}
  localparam logic [19:0] TBL [0:15] = '{
    {3'b110, 1'b0, 16'hFFFE},  // R2 timer
    {3'b110, 1'b0, 16'hFFFF},  // R2
    {3'b110, 1'b1, 16'h0000},  // R7 wrap sets flag
    {3'b100, 1'b1, 16'h0000},  // R6 stopped
    {3'b100, 1'b1, 16'h0000},  // R6
    {3'b011, 1'b1, 16'h0001},  // R3 1 then 0 counts
    {3'b011, 1'b1, 16'h0001},  // R3 steady low
    {3'b111, 1'b1, 16'h0001},  // R3 rising ignored
    {3'b011, 1'b1, 16'h0002},  // R3
    {3'b111, 1'b1, 16'h0002},  // R3
    {3'b001, 1'b1, 16'h0002},  // R6 edge while stopped dropped
    {3'b111, 1'b1, 16'h0002},  // R3
    {3'b111, 1'b1, 16'h0002},  // R3 steady high
    {3'b011, 1'b1, 16'h0003},  // R3
    {3'b010, 1'b1, 16'h0004},  // R2 back to timer
    {3'b111, 1'b1, 16'h0004}   // R3 rising, R7 flag sticky
  };

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] obs();
    return {ovf_flag, cnt_hi, cnt_lo};
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; sel_count = 1'b0; ev_pin = 1'b1;
    wr_lo = 1'b0; wr_hi = 1'b0; wr_data = 8'h00; clr_ovf = 1'b0;
    repeat (3) @(negedge clk_osc);
    check("R1 reset state", obs(), 17'h0_0000);
    rst_n = 1'b1;
    run_en = 1'b1;
    // Align to machine cycles: wait for the first timer increment
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_osc);
      if (cnt_lo != 8'h00) break;
    end
    check("R2 first increment", obs(), 17'h0_0001);
    repeat (12) @(negedge clk_osc);
    check("R2 period 12 clocks", obs(), 17'h0_0002);

    // Preset window: stopped, load 0xFFFD
    run_en = 1'b0;
    wr_hi = 1'b1; wr_data = 8'hFF;
    @(negedge clk_osc);
    wr_hi = 1'b0; wr_lo = 1'b1; wr_data = 8'hFD;
    @(negedge clk_osc);
    wr_lo = 1'b0;
    repeat (10) @(negedge clk_osc);
    check("R8 byte loads", obs(), 17'h0_FFFD);

    for (int i = 0; i < 16; i++) begin
      {ev_pin, run_en, sel_count} = TBL[i][19:17];
      repeat (12) @(negedge clk_osc);
      check($sformatf("R2/R3/R6/R7 vector %0d", i), obs(), TBL[i][16:0]);
    end

    // R7: clear the sticky flag (event mode, pin steady high)
    clr_ovf = 1'b1;
    @(negedge clk_osc);
    clr_ovf = 1'b0;
    repeat (11) @(negedge clk_osc);
    check("R7 flag cleared", obs(), 17'h0_0004);

    // R5: low glitch placed between two sampling points
    repeat (6) @(negedge clk_osc);
    ev_pin = 1'b0;
    repeat (3) @(negedge clk_osc);
    ev_pin = 1'b1;
    repeat (15) @(negedge clk_osc);
    check("R5 glitch not counted", obs(), 17'h0_0004);

    // R8: write lands on the commit clock of a timer increment
    sel_count = 1'b0;
    repeat (11) @(negedge clk_osc);
    wr_lo = 1'b1; wr_data = 8'h40;
    @(negedge clk_osc);
    wr_lo = 1'b0;
    check("R8 write beats increment", obs(), 17'h0_0040);

    // R7: wrap and clear in the same clock, the flag stays set
    wr_hi = 1'b1; wr_data = 8'hFF;
    @(negedge clk_osc);
    wr_hi = 1'b0; wr_lo = 1'b1;
    @(negedge clk_osc);
    wr_lo = 1'b0;
    repeat (9) @(negedge clk_osc);
    clr_ovf = 1'b1;
    @(negedge clk_osc);
    clr_ovf = 1'b0;
    check("R7 wrap beats clear", obs(), 17'h1_0000);

    // R4: event committed 7 clocks after its sample, not before
    sel_count = 1'b1; ev_pin = 1'b1;
    repeat (12) @(negedge clk_osc);
    ev_pin = 1'b0;
    repeat (11) @(negedge clk_osc);
    check("R4 not yet committed", obs(), 17'h1_0000);
    @(negedge clk_osc);
    check("R4 committed at load phase", obs(), 17'h1_0001);

    // R1: asynchronous reset mid-run
    @(negedge clk_osc);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", obs(), 17'h0_0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule